// File: doc/BRIEF.md
# Image Front-End Offset and Gain Calibration Controller

This block sits on the host side of a three-channel (red, green, blue) image digitizer. It owns the per-channel offset and gain codes of the analog front end and tunes them automatically. The block first loads a known starting point: a mode word, a neutral offset code and unity gain on every channel. It then runs a loop. It measures a dark line and pulls each offset code down by the measured black level. It measures a white line and, unless every channel already reads close to converter full scale, writes new gain codes. It finds each gain code by inverting the front end's gain law, gain = 40/(40 − X).

The block is driven by a register-write request port, a stream of 12-bit converter samples tagged with a channel number, and two strobes that mark the start and the end of a scanned line. Two level outputs tell the line sequencer which kind of line the block is waiting for. The loop ends when the white level converges or when the iteration budget runs out.

Top module: `cal_ctrl`

## Requirements
- R1: After reset the block is idle: `busy_o`, `done_o`, `err_o`, `wr_valid_o`, `scan_dark_o` and `scan_white_o` are all low.
- R2: A `start_i` pulse while not busy issues seven writes in this order: address 0 carrying `mode_i`, addresses 1, 2, 3 (red, green, blue offset) carrying C0h, then addresses 4, 5, 6 (red, green, blue gain) carrying 00h. Address 7 is never written.
- R3: A write request holds `wr_valid_o`, `wr_addr_o` and `wr_data_o` unchanged until it is accepted in a cycle with `wr_ready_i` high.
- R4: After the start-up writes, `scan_dark_o` is high. Each channel's level is the floor of the sum of its first 64 samples divided by 64. Only samples strictly between `line_start_i` and `line_end_i` with tag 0 (red), 1 (green) or 2 (blue) count. Tag 3, samples outside a line and samples beyond the 64th are ignored.
- R5: After a dark line, each offset code becomes max(0, code − floor((5·level + 4)/8)). The new codes are written to addresses 1, 2, 3 in that order, and `scan_white_o` then goes high.
- R6: After a white line, if every channel level is at least 4014 (within 2% of 4095), `done_o` goes high, `busy_o` drops, and no gain write is issued.
- R7: Otherwise each gain code X becomes 40 − floor(((40 − X)·level + 2047)/4095), capped at 31. The new codes are written to addresses 4, 5, 6, and a new dark scan begins.
- R8: If the fourth white line still fails R6, the gains of R7 are written and the block then stops with `err_o` high and `busy_o` low.
- R9: A `line_end_i` with no preceding `line_start_i` in the current scan phase has no effect.
- R10: `start_i` in the done or error state restarts from R2 and reloads C0h offsets and 00h gains.
- R11: `start_i` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a calibration run |
| mode_i | input | 8 | Mode word written to address 0 |
| wr_valid_o | output | 1 | Register write request pending |
| wr_ready_i | input | 1 | Write request accepted this cycle |
| wr_addr_o | output | 3 | Register address of the request |
| wr_data_o | output | 8 | Register data of the request |
| smp_valid_i | input | 1 | Sample present this cycle |
| smp_chan_i | input | 2 | Sample channel tag |
| smp_data_i | input | 12 | Converter sample |
| line_start_i | input | 1 | Line start strobe |
| line_end_i | input | 1 | Line end strobe |
| scan_dark_o | output | 1 | Waiting for or collecting a dark line |
| scan_white_o | output | 1 | Waiting for or collecting a white line |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | Converged |
| err_o | output | 1 | Iteration budget exhausted |

## Verification
Dark lines use black levels from zero up to near full scale. They separate the rounded 5/8 correction from the clamp at code zero, and the repeated loop shows that corrections build on the previously written code rather than on C0h. White lines sweep the level from a few hundred codes to full scale across ten restarts. This separates the rounded inversion of the gain law, the cap at 31 for very dark whites, and the 2% stop threshold. Junk samples on tag 3, before the line and past the 64th sample must leave the written codes unchanged. A run that never converges shows the fourth-iteration stop, and stray strobes and a mid-run start show that they are ignored.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADDR_CFG   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_OFS0  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_GAIN0 = 3'd4;

  typedef enum logic [3:0] {
    ST_IDLE, ST_INIT, ST_DARK, ST_OFS, ST_WHITE, ST_GDIV, ST_GWR, ST_DONE, ST_ERR
  } cal_state_e;
endpackage

// File: rtl/cal_line_avg.sv
module cal_line_avg #(
  parameter int NCH   = 3,
  parameter int DW    = 12,
  parameter int NSAMP = 64,
  parameter int CW    = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clear_i,
  input  logic                   en_i,
  input  logic                   valid_i,
  input  logic [CW-1:0]          chan_i,
  input  logic [DW-1:0]          data_i,
  output logic [NCH-1:0][DW-1:0] mean_o
);
  localparam int SHIFT = $clog2(NSAMP);
  localparam int SW    = DW + SHIFT;
  localparam int NW    = $clog2(NSAMP + 1);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [SW-1:0] sum_q;
    logic [NW-1:0] cnt_q;
    logic          take;

    assign take = en_i && valid_i && (chan_i == CW'(g)) && (cnt_q < NW'(NSAMP));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sum_q <= '0;
        cnt_q <= '0;
      end else if (clear_i) begin
        sum_q <= '0;
        cnt_q <= '0;
      end else if (take) begin
        sum_q <= sum_q + SW'(data_i);
        cnt_q <= cnt_q + 1'b1;
      end
    end

    assign mean_o[g] = sum_q[SW-1:SHIFT];
  end
endmodule

// File: rtl/cal_ofs_calc.sv
module cal_ofs_calc #(
  parameter int DW = 12,
  parameter int OW = 8
) (
  input  logic [DW-1:0] mean_i,
  input  logic [OW-1:0] cur_i,
  output logic [OW-1:0] new_o
);
  localparam int PW = (DW + 3 > OW) ? DW + 3 : OW;

  logic [PW-1:0] m5;
  logic [PW-1:0] corr;
  logic [PW-1:0] cur_w;

  // 5/8 code step per LSB, round half up
  assign m5    = PW'({mean_i, 2'b00}) + PW'(mean_i) + PW'(4);
  assign corr  = m5 >> 3;
  assign cur_w = PW'(cur_i);
  assign new_o = (cur_w > corr) ? OW'(cur_w - corr) : '0;
endmodule

// File: rtl/cal_gain_div.sv
module cal_gain_div #(
  parameter int NW  = 18,
  parameter int QW  = 6,
  parameter int DEN = 4095
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [NW-1:0] num_i,
  output logic          done_o,
  output logic [QW-1:0] q_o
);
  localparam int RW = NW + 1;

  logic [RW-1:0] rem_q;
  logic          run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      q_o    <= '0;
      run_q  <= 1'b0;
      done_o <= 1'b0;
    end else if (start_i) begin
      rem_q  <= RW'(num_i) + RW'(DEN / 2);
      q_o    <= '0;
      run_q  <= 1'b1;
      done_o <= 1'b0;
    end else if (run_q) begin
      if (rem_q >= RW'(DEN)) begin
        rem_q <= rem_q - RW'(DEN);
        q_o   <= q_o + 1'b1;
      end else begin
        run_q  <= 1'b0;
        done_o <= 1'b1;
      end
    end else begin
      done_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cal_ctrl.sv
module cal_ctrl #(
  parameter int NCH      = 3,
  parameter int DW       = 12,
  parameter int CW       = 2,
  parameter int RW       = 8,
  parameter int GW       = 5,
  parameter int NSAMP    = 64,
  parameter int MAX_ITER = 4,
  parameter int OFS_INIT = 192
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [RW-1:0]             mode_i,
  output logic                      wr_valid_o,
  input  logic                      wr_ready_i,
  output logic [cal_pkg::ADDR_W-1:0] wr_addr_o,
  output logic [RW-1:0]             wr_data_o,
  input  logic                      smp_valid_i,
  input  logic [CW-1:0]             smp_chan_i,
  input  logic [DW-1:0]             smp_data_i,
  input  logic                      line_start_i,
  input  logic                      line_end_i,
  output logic                      scan_dark_o,
  output logic                      scan_white_o,
  output logic                      busy_o,
  output logic                      done_o,
  output logic                      err_o
);
  import cal_pkg::*;

  localparam int AW    = ADDR_W;
  localparam int FULL  = (1 << DW) - 1;
  localparam int THR   = FULL - FULL / 50;
  localparam int KG    = 40;              // gain = KG/(KG - X)
  localparam int KW    = $clog2(KG + 1);
  localparam int GMAX  = (1 << GW) - 1;
  localparam int PNW   = KW + DW;
  localparam int NINIT = 1 + 2 * NCH;
  localparam int IDXW  = $clog2(NINIT);
  localparam int CIW   = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int ITW   = $clog2(MAX_ITER + 1);

  cal_state_e                st_q;
  logic [IDXW-1:0]           idx_q;
  logic [ITW-1:0]            iter_q;
  logic                      in_line_q;
  logic                      div_run_q;
  logic [NCH-1:0][RW-1:0]    off_q;
  logic [NCH-1:0][GW-1:0]    gain_q;

  logic                      waiting;
  logic                      avg_clear;
  logic                      avg_en;
  logic [NCH-1:0][DW-1:0]    mean_v;
  logic [NCH-1:0][RW-1:0]    ofs_new;
  logic [NCH-1:0]            close_v;
  logic                      all_close;
  logic [CIW-1:0]            chi;
  logic [CIW-1:0]            ofs_sel;
  logic [CIW-1:0]            gain_sel;
  logic [KW-1:0]             head;
  logic [PNW-1:0]            div_num;
  logic                      div_start;
  logic                      div_done;
  logic [KW-1:0]             div_q;
  logic [KW-1:0]             gsum;
  logic [GW-1:0]             gsat;
  logic                      wr_acc;
  logic                      last_ch;

  assign waiting   = (st_q == ST_DARK) || (st_q == ST_WHITE);
  assign avg_clear = waiting && line_start_i;
  assign avg_en    = in_line_q && !line_end_i;

  cal_line_avg #(.NCH(NCH), .DW(DW), .NSAMP(NSAMP), .CW(CW)) u_avg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (avg_clear),
    .en_i    (avg_en),
    .valid_i (smp_valid_i),
    .chan_i  (smp_chan_i),
    .data_i  (smp_data_i),
    .mean_o  (mean_v)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    cal_ofs_calc #(.DW(DW), .OW(RW)) u_ofs (
      .mean_i (mean_v[g]),
      .cur_i  (off_q[g]),
      .new_o  (ofs_new[g])
    );
    assign close_v[g] = mean_v[g] >= DW'(THR);
  end

  assign all_close = &close_v;

  assign chi      = idx_q[CIW-1:0];
  assign ofs_sel  = CIW'(idx_q - IDXW'(1));
  assign gain_sel = CIW'(idx_q - IDXW'(NCH + 1));
  assign last_ch  = (idx_q == IDXW'(NCH - 1));

  assign head      = KW'(KG) - KW'(gain_q[chi]);
  assign div_num   = PNW'(head) * PNW'(mean_v[chi]);
  assign div_start = (st_q == ST_GDIV) && !div_run_q;

  cal_gain_div #(.NW(PNW), .QW(KW), .DEN(FULL)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (div_start),
    .num_i   (div_num),
    .done_o  (div_done),
    .q_o     (div_q)
  );

  assign gsum = KW'(KG) - div_q;
  assign gsat = (gsum > KW'(GMAX)) ? GW'(GMAX) : gsum[GW-1:0];

  always_comb begin
    wr_valid_o = 1'b0;
    wr_addr_o  = '0;
    wr_data_o  = '0;
    unique case (st_q)
      ST_INIT: begin
        wr_valid_o = 1'b1;
        wr_addr_o  = AW'(idx_q);
        if (idx_q == '0)                   wr_data_o = mode_i;
        else if (idx_q <= IDXW'(NCH))      wr_data_o = off_q[ofs_sel];
        else                               wr_data_o = RW'(gain_q[gain_sel]);
      end
      ST_OFS: begin
        wr_valid_o = 1'b1;
        wr_addr_o  = ADDR_OFS0 + AW'(idx_q);
        wr_data_o  = off_q[chi];
      end
      ST_GWR: begin
        wr_valid_o = 1'b1;
        wr_addr_o  = ADDR_GAIN0 + AW'(idx_q);
        wr_data_o  = RW'(gain_q[chi]);
      end
      default: ;
    endcase
  end

  assign wr_acc = wr_valid_o && wr_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      idx_q     <= '0;
      iter_q    <= '0;
      in_line_q <= 1'b0;
      div_run_q <= 1'b0;
      off_q     <= '0;
      gain_q    <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_DONE, ST_ERR: begin
          if (start_i) begin
            st_q      <= ST_INIT;
            idx_q     <= '0;
            iter_q    <= '0;
            in_line_q <= 1'b0;
            off_q     <= {NCH{RW'(OFS_INIT)}};
            gain_q    <= '0;
          end
        end
        ST_INIT: begin
          if (wr_acc) begin
            if (idx_q == IDXW'(NINIT - 1)) begin
              st_q  <= ST_DARK;
              idx_q <= '0;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_DARK, ST_WHITE: begin
          if (line_start_i) begin
            in_line_q <= 1'b1;
          end else if (line_end_i && in_line_q) begin
            in_line_q <= 1'b0;
            idx_q     <= '0;
            if (st_q == ST_DARK) begin
              off_q <= ofs_new;
              st_q  <= ST_OFS;
            end else if (all_close) begin
              st_q <= ST_DONE;
            end else begin
              st_q <= ST_GDIV;
            end
          end
        end
        ST_OFS: begin
          if (wr_acc) begin
            if (last_ch) begin
              st_q  <= ST_WHITE;
              idx_q <= '0;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_GDIV: begin
          if (!div_run_q) begin
            div_run_q <= 1'b1;
          end else if (div_done) begin
            gain_q[chi] <= gsat;
            div_run_q   <= 1'b0;
            if (last_ch) begin
              st_q  <= ST_GWR;
              idx_q <= '0;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_GWR: begin
          if (wr_acc) begin
            if (last_ch) begin
              idx_q <= '0;
              if (iter_q == ITW'(MAX_ITER - 1)) begin
                st_q <= ST_ERR;
              end else begin
                iter_q <= iter_q + 1'b1;
                st_q   <= ST_DARK;
              end
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign scan_dark_o  = (st_q == ST_DARK);
  assign scan_white_o = (st_q == ST_WHITE);
  assign done_o       = (st_q == ST_DONE);
  assign err_o        = (st_q == ST_ERR);
  assign busy_o       = !((st_q == ST_IDLE) || (st_q == ST_DONE) || (st_q == ST_ERR));
endmodule

// File: rtl/cal_ctrl_chk.sv
module cal_ctrl_chk #(
  parameter int AW = 3,
  parameter int RW = 8,
  parameter int GW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic          wr_valid_o,
  input logic          wr_ready_i,
  input logic [AW-1:0] wr_addr_o,
  input logic [RW-1:0] wr_data_o,
  input logic          scan_dark_o,
  input logic          scan_white_o,
  input logic          line_start_i,
  input logic          line_end_i
);
  localparam logic [RW-1:0] GMAX = RW'((1 << GW) - 1);

  p_wr_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o));

  p_addr_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> wr_addr_o != AW'(7));

  p_start_init_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> wr_valid_o && wr_addr_o == '0);

  p_gain_cap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && wr_addr_o >= AW'(4) |-> wr_data_o <= GMAX);

  p_phase_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({scan_dark_o, scan_white_o, wr_valid_o, done_o, err_o}));

  p_busy_start_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_dark_o && start_i && !line_start_i && !line_end_i |=> scan_dark_o);

  p_done_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o && !busy_o);

  p_err_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !start_i |=> err_o && !busy_o);
endmodule

bind cal_ctrl cal_ctrl_chk #(.AW(cal_pkg::ADDR_W), .RW(RW), .GW(GW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .err_o        (err_o),
  .wr_valid_o   (wr_valid_o),
  .wr_ready_i   (wr_ready_i),
  .wr_addr_o    (wr_addr_o),
  .wr_data_o    (wr_data_o),
  .scan_dark_o  (scan_dark_o),
  .scan_white_o (scan_white_o),
  .line_start_i (line_start_i),
  .line_end_i   (line_end_i)
);

// File: tb/cal_ctrl_test.sv
module cal_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  mode_i = '0;
  logic        wr_valid_o;
  logic        wr_ready_i = 1'b0;
  logic [2:0]  wr_addr_o;
  logic [7:0]  wr_data_o;
  logic        smp_valid_i = 1'b0;
  logic [1:0]  smp_chan_i = '0;
  logic [11:0] smp_data_i = '0;
  logic        line_start_i = 1'b0;
  logic        line_end_i = 1'b0;
  logic        scan_dark_o, scan_white_o, busy_o, done_o, err_o;

  always #4 clk = ~clk;

  cal_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .smp_valid_i(smp_valid_i), .smp_chan_i(smp_chan_i),
    .smp_data_i(smp_data_i), .line_start_i(line_start_i), .line_end_i(line_end_i),
    .scan_dark_o(scan_dark_o), .scan_white_o(scan_white_o), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int off[3];
  int gn[3];
  int mres[3];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int ofs_new(input int cur, input int m);
    int corr = (5 * m + 4) / 8;
    return (cur > corr) ? cur - corr : 0;
  endfunction

  function automatic int gain_new(input int x, input int w);
    int q = ((40 - x) * w + 2047) / 4095;
    int r = 40 - q;
    return (r > 31) ? 31 : r;
  endfunction

  task automatic expect_wr(input int a, input int d, input string req, input bit stall);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!wr_valid_o && n < 2000);
    chk(wr_valid_o === 1'b1, req, int'(wr_valid_o), 1);
    chk(int'(wr_addr_o) == a, req, int'(wr_addr_o), a);
    chk(int'(wr_data_o) == d, req, int'(wr_data_o), d);
    if (stall) begin
      repeat (3) @(negedge clk);
      chk(wr_valid_o && int'(wr_addr_o) == a && int'(wr_data_o) == d, "R3",
          int'(wr_data_o), d);
    end
    wr_ready_i = 1'b1;
    @(negedge clk);
    wr_ready_i = 1'b0;
  endtask

  task automatic wait_for(input bit white);
    int n = 0;
    while (((white ? scan_white_o : scan_dark_o) !== 1'b1) && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic send_line(input int b0, input int b1, input int b2, input bit junk);
    int base[3];
    int sum[3];
    base[0] = b0; base[1] = b1; base[2] = b2;
    for (int c = 0; c < 3; c++) sum[c] = 0;
    if (junk) begin
      smp_valid_i = 1'b1; smp_chan_i = 2'd0; smp_data_i = 12'hfff;
      @(negedge clk);
      smp_valid_i = 1'b0;
    end
    line_start_i = 1'b1;
    @(negedge clk);
    line_start_i = 1'b0;
    for (int k = 0; k < 64; k++) begin
      for (int c = 0; c < 3; c++) begin
        int v = base[c] + (k % 5);
        if (v > 4095) v = 4095;
        smp_valid_i = 1'b1; smp_chan_i = 2'(c); smp_data_i = 12'(v);
        sum[c] += v;
        @(negedge clk);
      end
      if (junk && k == 10) begin
        smp_chan_i = 2'd3; smp_data_i = 12'hfff;
        @(negedge clk);
      end
    end
    if (junk) begin
      for (int e = 0; e < 6; e++) begin
        smp_chan_i = 2'(e % 3); smp_data_i = 12'hfff;
        @(negedge clk);
      end
    end
    smp_valid_i = 1'b0;
    line_end_i = 1'b1;
    @(negedge clk);
    line_end_i = 1'b0;
    for (int c = 0; c < 3; c++) mres[c] = sum[c] / 64;
  endtask

  task automatic run_init(input int mode, input string req, input bit stall);
    mode_i = 8'(mode);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int c = 0; c < 3; c++) begin
      off[c] = 192;
      gn[c] = 0;
    end
    expect_wr(0, mode, req, stall);
    for (int c = 0; c < 3; c++) expect_wr(1 + c, 192, req, 1'b0);
    for (int c = 0; c < 3; c++) expect_wr(4 + c, 0, req, 1'b0);
  endtask

  task automatic run_iter(input int d0, input int d1, input int d2,
                          input int w0, input int w1, input int w2,
                          input bit junk, output bit closed);
    wait_for(1'b0);
    chk(scan_dark_o === 1'b1, "R4", int'(scan_dark_o), 1);
    send_line(d0, d1, d2, junk);
    for (int c = 0; c < 3; c++) begin
      off[c] = ofs_new(off[c], mres[c]);
      expect_wr(1 + c, off[c], "R4 R5", 1'b0);
    end
    wait_for(1'b1);
    chk(scan_white_o === 1'b1, "R5", int'(scan_white_o), 1);
    send_line(w0, w1, w2, junk);
    closed = (mres[0] >= 4014) && (mres[1] >= 4014) && (mres[2] >= 4014);
    if (closed) begin
      @(negedge clk);
      chk(done_o && !busy_o && !wr_valid_o, "R6", int'(done_o), 1);
    end else begin
      for (int c = 0; c < 3; c++) begin
        gn[c] = gain_new(gn[c], mres[c]);
        expect_wr(4 + c, gn[c], "R7", 1'b0);
      end
    end
  endtask

  initial begin
    bit cl;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy_o && !done_o && !err_o, "R1", int'(busy_o), 0);
    chk(!wr_valid_o && !scan_dark_o && !scan_white_o, "R1", int'(wr_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // S1: converge on first pass
    run_init(8'h25, "R2", 1'b1);
    run_iter(100, 40, 0, 4040, 4020, 4090, 1'b0, cl);
    chk(cl, "R6", int'(cl), 1);

    // S2: restart from done, stray end, clamp, cap, ignored start
    run_init(8'h01, "R10", 1'b0);
    wait_for(1'b0);
    line_end_i = 1'b1;
    @(negedge clk);
    line_end_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(scan_dark_o && !wr_valid_o, "R9", int'(scan_dark_o), 1);
    run_iter(4000, 4000, 4000, 2000, 500, 1000, 1'b1, cl);
    chk(!cl, "R7", int'(cl), 0);
    wait_for(1'b0);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    chk(scan_dark_o && !wr_valid_o, "R11", int'(wr_valid_o), 0);
    run_iter(8, 0, 3, 4050, 4050, 4050, 1'b1, cl);
    chk(cl, "R6", int'(cl), 1);

    // S3: never converges
    run_init(8'h04, "R10", 1'b0);
    for (int it = 0; it < 4; it++) begin
      run_iter(20 + it, 5, 60, 1000, 2000 + it * 100, 3000, 1'b0, cl);
    end
    chk(err_o && !busy_o, "R8", int'(err_o), 1);
    repeat (20) @(negedge clk);
    chk(err_o && !wr_valid_o && !scan_dark_o, "R8", int'(err_o), 1);

    // S4: sweep of dark and white levels
    for (int t = 0; t < 10; t++) begin
      run_init(t, "R10", 1'b0);
      run_iter(t * 45, t * 13, 400 - t * 40, 300 + t * 350, 4095 - t * 390, 150 + t * 420,
               1'b0, cl);
      if (!cl) begin
        run_iter(t, 1, 2, 4060, 4070, 4080, 1'b0, cl);
        chk(cl, "R6", int'(cl), 1);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule